// File: doc/BRIEF.md
# Rank-Bus Aware Command Picker

This block chooses, each channel cycle, which entry of a pending request buffer is sent to the DRAM next. It serves a channel whose ranks are grouped behind relay buffers. The ranks in a group share one slower rank bus. The memory controller keeps all DRAM timing in channel cycles, as if every rank were wired straight to the fast channel with the relay delay folded in. On top of that timing, this picker adds one extra rule: two commands aimed at ranks on the same rank bus must be separated by a programmable number of channel cycles. With that spacing in place, a channel schedule free of conflicts also gives rank buses free of conflicts.

Among the entries that may issue, the picker ranks the candidates by request class first and by row-buffer hit second. In normal mode reads come before writes. The picker switches into a write-drain mode when pending writes pass half of the buffer, and it stays there until they fall below a quarter of the buffer. In that mode writes come first, and row hits still win within the class. Any remaining tie goes to the lowest index, which the surrounding buffer keeps in arrival order.

The outputs are an issue strobe and the index of the chosen entry, both formed combinationally in the same cycle. The surrounding buffer retires the granted entry at the next clock edge.

Top module: `rankbus_cmd_sched`

## Requirements
- R1: While reset is held, issueValid stays low. The first cycle after release is in normal (read-first) mode, even if the write count is already above the high watermark.
- R2: In normal mode a valid read on an unblocked bus beats any write. Within a class, an entry with reqRowHit=1 beats one with reqRowHit=0.
- R3: Among the candidates of the best class and hit tier, the entry with the lowest index is granted.
- R4: issueValid is high exactly when some entry with reqValid=1 sits on a rank bus that is not blocked. When it is high, issueIdx names such an entry.
- R5: When the count of entries with reqValid=1 and reqIsWrite=1 exceeds ENTRIES/2 in a cycle, drain mode is active from the next cycle on. A count of exactly ENTRIES/2 does not enter it.
- R6: Drain mode ends on the cycle after the write count drops below ENTRIES/4. Counts from ENTRIES/4 up to ENTRIES/2 leave the current mode unchanged, in either direction.
- R7: In drain mode, writes beat reads, including reads that hit an open row. Among the writes, row hits beat misses.
- R8: After an issue to a rank bus in cycle t, with G = gapCycles, no further issue goes to that bus before cycle t+G. A request that is waiting may issue at t+G. When G is 0 or 1, the bus is not restricted beyond one grant per cycle.
- R9: A rank r belongs to rank bus r / RANKS_PER_BUS, so ranks 0 and 1 share bus 0 and ranks 2 and 3 share bus 1 for the default grouping of two. A blocked bus does not hold back requests on another bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | ENTRIES | Entry holds a pending request |
| reqIsWrite | input | ENTRIES | 1 = write request, 0 = read request |
| reqRowHit | input | ENTRIES | 1 = request targets the row already open in its bank |
| reqRank | input | ENTRIES*RANK_W | Target rank of each entry; entry i occupies bits [i*RANK_W +: RANK_W] |
| gapCycles | input | GAP_W | Minimum spacing, in channel cycles, between commands on one rank bus |
| issueValid | output | 1 | A request is granted this cycle |
| issueIdx | output | IDX_W | Index of the granted entry |

## Verification
The priority logic is swept through every combination of valid, read/write and row-hit over four entries. This tells the class order, the hit order and the lowest-index tie-break apart from one another. The drain controller is walked through write counts at each watermark and one step on either side of it. These steps show the one-cycle entry and exit latency, the hysteresis band, and hit-first ordering inside the write class. Single-bus and dual-bus request mixes are run under several gap values. They show the exact spacing to the cycle, that a rank is held back by traffic from another rank on its own bus, and that the other bus stays free.

// File: rtl/rbs_pkg.sv
`timescale 1ns/1ps
package rbs_pkg;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_DRAIN  = 1'b1
  } schedMode_e;

  // strobes from the control half to the selection datapath
  typedef struct packed {
    logic drainMode;
  } ctrlStrobes_t;

endpackage

// File: rtl/rbs_gap_timer.sv
`timescale 1ns/1ps
module rbs_gap_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [GAP_W-1:0] gapCycles,
  output logic             blocked
);

  logic [GAP_W-1:0] remain;

  // after an issue in cycle t, remain reaches zero in cycle t+gap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (load) begin
      remain <= (gapCycles == '0) ? '0 : gapCycles - 1'b1;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign blocked = (remain != '0);

endmodule

// File: rtl/rbs_ctrl.sv
`timescale 1ns/1ps
module rbs_ctrl
  import rbs_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int BUSES   = 2,
  parameter int BUS_W   = 1,
  parameter int GAP_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRIES-1:0] reqValid,
  input  logic [ENTRIES-1:0] reqIsWrite,
  input  logic [GAP_W-1:0]   gapCycles,
  input  logic               issueValid,
  input  logic [BUS_W-1:0]   issueBus,
  output ctrlStrobes_t       ctrl,
  output logic [BUSES-1:0]   busBlocked
);

  localparam int CNT_W   = $clog2(ENTRIES + 1);
  localparam int HIGH_WM = ENTRIES / 2;
  localparam int LOW_WM  = ENTRIES / 4;

  logic [CNT_W-1:0] writeCnt;
  schedMode_e       mode;
  schedMode_e       modeNext;

  always_comb begin
    writeCnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      writeCnt += CNT_W'(reqValid[i] & reqIsWrite[i]);
    end
  end

  always_comb begin
    modeNext = mode;
    unique case (mode)
      MODE_NORMAL: if (writeCnt > CNT_W'(HIGH_WM)) modeNext = MODE_DRAIN;
      MODE_DRAIN:  if (writeCnt < CNT_W'(LOW_WM))  modeNext = MODE_NORMAL;
      default:     modeNext = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_NORMAL;
    else       mode <= modeNext;
  end

  assign ctrl.drainMode = (mode == MODE_DRAIN);

  for (genvar b = 0; b < BUSES; b++) begin : g_bus
    rbs_gap_timer #(.GAP_W(GAP_W)) u_timer (
      .clk       (clk),
      .rstN      (rstN),
      .load      (issueValid && (issueBus == BUS_W'(b))),
      .gapCycles (gapCycles),
      .blocked   (busBlocked[b])
    );
  end

endmodule

// File: rtl/rbs_select.sv
`timescale 1ns/1ps
module rbs_select
  import rbs_pkg::*;
#(
  parameter int ENTRIES       = 64,
  parameter int RANK_W        = 2,
  parameter int RANKS_PER_BUS = 2,
  parameter int BUSES         = 2,
  parameter int BUS_W         = 1,
  parameter int IDX_W         = 6
) (
  input  logic                      rstN,
  input  logic [ENTRIES-1:0]        reqValid,
  input  logic [ENTRIES-1:0]        reqIsWrite,
  input  logic [ENTRIES-1:0]        reqRowHit,
  input  logic [ENTRIES*RANK_W-1:0] reqRank,
  input  ctrlStrobes_t              ctrl,
  input  logic [BUSES-1:0]          busBlocked,
  output logic                      issueValid,
  output logic [IDX_W-1:0]          issueIdx,
  output logic [BUS_W-1:0]          issueBus
);

  logic [BUS_W-1:0]   entBus [ENTRIES];
  logic [ENTRIES-1:0] eligible;
  logic [ENTRIES-1:0] prefCls;
  logic [ENTRIES-1:0] tierPrefHit, tierPrefMiss, tierOtherHit, tierOtherMiss;
  logic [ENTRIES-1:0] chosen;
  logic               found;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [RANK_W-1:0] rankI;
    assign rankI       = reqRank[i*RANK_W +: RANK_W];
    assign entBus[i]   = BUS_W'(int'(rankI) / RANKS_PER_BUS);
    assign eligible[i] = reqValid[i] & ~busBlocked[entBus[i]];
    // drain mode swaps which class is preferred
    assign prefCls[i]  = (reqIsWrite[i] == ctrl.drainMode);
  end

  assign tierPrefHit   = eligible &  prefCls &  reqRowHit;
  assign tierPrefMiss  = eligible &  prefCls & ~reqRowHit;
  assign tierOtherHit  = eligible & ~prefCls &  reqRowHit;
  assign tierOtherMiss = eligible & ~prefCls & ~reqRowHit;

  always_comb begin
    if (|tierPrefHit)       chosen = tierPrefHit;
    else if (|tierPrefMiss) chosen = tierPrefMiss;
    else if (|tierOtherHit) chosen = tierOtherHit;
    else                    chosen = tierOtherMiss;
  end

  // lowest index wins inside the chosen tier
  always_comb begin
    found    = 1'b0;
    issueIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (chosen[i]) begin
        found    = 1'b1;
        issueIdx = IDX_W'(i);
      end
    end
  end

  assign issueValid = rstN & found;
  assign issueBus   = entBus[issueIdx];

endmodule

// File: rtl/rankbus_cmd_sched.sv
`timescale 1ns/1ps
module rankbus_cmd_sched
  import rbs_pkg::*;
#(
  parameter int ENTRIES       = 64,
  parameter int RANKS         = 4,
  parameter int RANKS_PER_BUS = 2,
  parameter int GAP_W         = 4,
  localparam int IDX_W        = $clog2(ENTRIES),
  localparam int RANK_W       = $clog2(RANKS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ENTRIES-1:0]        reqValid,
  input  logic [ENTRIES-1:0]        reqIsWrite,
  input  logic [ENTRIES-1:0]        reqRowHit,
  input  logic [ENTRIES*RANK_W-1:0] reqRank,
  input  logic [GAP_W-1:0]          gapCycles,
  output logic                      issueValid,
  output logic [IDX_W-1:0]          issueIdx
);

  localparam int BUSES = RANKS / RANKS_PER_BUS;
  localparam int BUS_W = (BUSES > 1) ? $clog2(BUSES) : 1;

  ctrlStrobes_t     ctrlBus;
  logic [BUSES-1:0] busBlocked;
  logic [BUS_W-1:0] issueBus;
  logic             drainModeTap;

  assign drainModeTap = ctrlBus.drainMode;

  rbs_ctrl #(
    .ENTRIES (ENTRIES),
    .BUSES   (BUSES),
    .BUS_W   (BUS_W),
    .GAP_W   (GAP_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqIsWrite (reqIsWrite),
    .gapCycles  (gapCycles),
    .issueValid (issueValid),
    .issueBus   (issueBus),
    .ctrl       (ctrlBus),
    .busBlocked (busBlocked)
  );

  rbs_select #(
    .ENTRIES       (ENTRIES),
    .RANK_W        (RANK_W),
    .RANKS_PER_BUS (RANKS_PER_BUS),
    .BUSES         (BUSES),
    .BUS_W         (BUS_W),
    .IDX_W         (IDX_W)
  ) u_sel (
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqIsWrite (reqIsWrite),
    .reqRowHit  (reqRowHit),
    .reqRank    (reqRank),
    .ctrl       (ctrlBus),
    .busBlocked (busBlocked),
    .issueValid (issueValid),
    .issueIdx   (issueIdx),
    .issueBus   (issueBus)
  );

endmodule

// File: rtl/rankbus_cmd_sched_chk.sv
`timescale 1ns/1ps
module rankbus_cmd_sched_chk #(
  parameter int ENTRIES       = 64,
  parameter int RANKS         = 4,
  parameter int RANKS_PER_BUS = 2,
  parameter int GAP_W         = 4,
  localparam int IDX_W        = $clog2(ENTRIES),
  localparam int RANK_W       = $clog2(RANKS)
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [ENTRIES-1:0]        reqValid,
  input logic [ENTRIES-1:0]        reqIsWrite,
  input logic [ENTRIES*RANK_W-1:0] reqRank,
  input logic [GAP_W-1:0]          gapCycles,
  input logic                      issueValid,
  input logic [IDX_W-1:0]          issueIdx,
  input logic                      drainMode
);

  localparam int BUSES   = RANKS / RANKS_PER_BUS;
  localparam int CW      = GAP_W + 1;
  localparam int HIGH_WM = ENTRIES / 2;
  localparam int LOW_WM  = ENTRIES / 4;

  int          wrCount;
  int          grantBus;
  logic [RANK_W-1:0] grantRank;

  assign wrCount   = $countones(reqValid & reqIsWrite);
  assign grantRank = reqRank[issueIdx*RANK_W +: RANK_W];
  assign grantBus  = int'(grantRank) / RANKS_PER_BUS;

  assert_reset_quiet_R1: assert property (@(posedge clk) !rstN |-> !issueValid);

  assert_grant_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> reqValid[issueIdx]);

  assert_drain_enter_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrCount > HIGH_WM) |=> drainMode);

  assert_drain_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrCount < LOW_WM) |=> !drainMode);

  assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrCount >= LOW_WM && wrCount <= HIGH_WM) |=> (drainMode == $past(drainMode)));

  for (genvar b = 0; b < BUSES; b++) begin : g_space
    logic [CW-1:0] sinceLast;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sinceLast <= '1;
      else if (issueValid && grantBus == b) sinceLast <= CW'(1);
      else if (sinceLast != '1) sinceLast <= sinceLast + 1'b1;
    end
    assert_bus_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
      (issueValid && grantBus == b) |-> (sinceLast >= {1'b0, gapCycles}));
  end

endmodule

bind rankbus_cmd_sched rankbus_cmd_sched_chk #(
  .ENTRIES       (ENTRIES),
  .RANKS         (RANKS),
  .RANKS_PER_BUS (RANKS_PER_BUS),
  .GAP_W         (GAP_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqIsWrite (reqIsWrite),
  .reqRank    (reqRank),
  .gapCycles  (gapCycles),
  .issueValid (issueValid),
  .issueIdx   (issueIdx),
  .drainMode  (drainModeTap)
);

// File: tb/rankbus_cmd_sched_bench.sv
`timescale 1ns/1ps
module rankbus_cmd_sched_bench;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [N-1:0] reqValid = '0;
  logic [N-1:0] reqIsWrite = '0;
  logic [N-1:0] reqRowHit = '0;
  logic [2*N-1:0] reqRank = '0;
  logic [3:0]  gapCycles = '0;
  logic        issueValid;
  logic [2:0]  issueIdx;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  rankbus_cmd_sched #(.ENTRIES(N), .RANKS(4), .RANKS_PER_BUS(2), .GAP_W(4)) u_rankbus_cmd_sched (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsWrite(reqIsWrite),
    .reqRowHit(reqRowHit), .reqRank(reqRank), .gapCycles(gapCycles),
    .issueValid(issueValid), .issueIdx(issueIdx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input int i, input bit v, input bit w, input bit h, input int r);
    reqValid[i]       = v;
    reqIsWrite[i]     = w;
    reqRowHit[i]      = h;
    reqRank[i*2 +: 2] = 2'(r);
  endtask

  task automatic clearReqs();
    reqValid = '0; reqIsWrite = '0; reqRowHit = '0; reqRank = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    clearReqs();
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  // expected grant from the requirement text: class, then hit, then index
  function automatic int refGrant(input bit drain, input bit [1:0] blk);
    int best = -1;
    int bestLvl = -1;
    for (int i = 0; i < N; i++) begin
      int lvl;
      int bus;
      bus = int'(reqRank[i*2 +: 2]) / 2;
      if (reqValid[i] && !blk[bus]) begin
        lvl = ((reqIsWrite[i] == drain) ? 2 : 0) + (reqRowHit[i] ? 1 : 0);
        if (lvl > bestLvl) begin bestLvl = lvl; best = i; end
      end
    end
    return best;
  endfunction

  // writes in entries 1..k, entry 0 a read hit on rank 0
  task automatic setWrites(input int k, input int hitIdx);
    @(posedge clk); #1;
    put(0, 1, 0, 1, 0);
    for (int i = 1; i < N; i++) put(i, i <= k, 1, i == hitIdx, i % 4);
  endtask

  task automatic gapRun(input int g);
    doReset();
    gapCycles = 4'(g);
    put(0, 1, 0, 1, 0);
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      chk($sformatf("R8 gap=%0d cycle %0d strobe", g, n), int'(issueValid),
          (g <= 1 || n % g == 0) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R1: quiet in reset, normal mode right after release
    put(0, 1, 0, 0, 0);
    for (int i = 1; i <= 5; i++) put(i, 1, 1, 0, i % 4);
    @(negedge clk);
    chk("R1 strobe in reset", int'(issueValid), 0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 first grant read", int'(issueIdx), 0);
    @(negedge clk);
    chk("R5 drain after release", int'(issueIdx), 1);

    // R4: nothing pending
    doReset();
    @(negedge clk);
    chk("R4 empty strobe", int'(issueValid), 0);

    // R2 R3 R4 exhaustive over four entries, gap 0
    for (int p = 0; p < 4096; p++) begin
      int exp;
      @(posedge clk); #1;
      for (int i = 0; i < 4; i++) put(i, p[3*i], p[3*i+1], p[3*i+2], i);
      @(negedge clk);
      exp = refGrant(1'b0, 2'b00);
      chk("R4 strobe", int'(issueValid), (exp >= 0) ? 1 : 0);
      if (exp >= 0) chk("R2 R3 grant", int'(issueIdx), exp);
    end

    // R5 R6 R7 drain watermarks (HI=4, LO=2)
    doReset();
    setWrites(4, 0);
    @(negedge clk); @(negedge clk);
    chk("R5 half not entered", int'(issueIdx), 0);
    setWrites(5, 0);
    @(negedge clk);
    chk("R5 one-cycle latency", int'(issueIdx), 0);
    @(negedge clk);
    chk("R5 drain write over read hit", int'(issueIdx), 1);
    setWrites(5, 4);
    @(negedge clk);
    chk("R7 hit-first among writes", int'(issueIdx), 4);
    setWrites(2, 0);
    @(negedge clk); @(negedge clk);
    chk("R6 held at quarter", int'(issueIdx), 1);
    setWrites(1, 0);
    @(negedge clk);
    chk("R6 exit latency", int'(issueIdx), 1);
    @(negedge clk);
    chk("R6 exit to reads", int'(issueIdx), 0);
    setWrites(3, 0);
    @(negedge clk); @(negedge clk);
    chk("R6 no re-entry below high", int'(issueIdx), 0);

    // R8 spacing on a single bus
    gapRun(0);
    gapRun(1);
    gapRun(3);
    gapRun(5);
    gapRun(15);

    // R9: rank1 shares bus 0 with rank0, rank3 sits on bus 1
    doReset();
    gapCycles = 4'd3;
    put(0, 1, 0, 1, 0);
    put(1, 1, 0, 0, 2);
    put(2, 1, 0, 1, 1);
    put(3, 1, 0, 1, 3);
    for (int n = 0; n < 18; n++) begin
      @(negedge clk);
      if (n % 3 == 2) begin
        chk($sformatf("R9 both blocked cycle %0d", n), int'(issueValid), 0);
      end else begin
        chk($sformatf("R9 strobe cycle %0d", n), int'(issueValid), 1);
        chk($sformatf("R9 grant cycle %0d", n), int'(issueIdx), (n % 3 == 0) ? 0 : 3);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule